// File: doc/BRIEF.md
# Indirect Table Access Controller

This block gives a host access to several internal classifier tables through a small window of 32-bit registers. The host first writes a pointer word. Its top nibble selects the target table and its low 28 bits give the entry index. The host then fills a bank of 17 staging words and writes a one-hot command word. The controller carries out the access against the selected table. When the access is finished, it sets the status bit that matches the command code. Software polls that bit.

The block holds the following tables:
- one packet table for each of three parsers;
- one tree table, shared by all parsers;
- one search-tree table, shared by all parsers;
- one result table, shared by all parsers.

Each table has its own entry width in words. A write commits the leading words of the staging bank in one step. A read copies a whole entry back into the leading staging words. The host then reads those words through the same data registers. Search-tree add, delete and search commands are accepted and flagged done. They do not touch any table.

Top module: `ind_access_ctrl`

## Requirements
- R1: After reset, the pointer, command, status and all staging registers read 0, and every table entry holds 0.
- R2: The pointer is at offset 0x04, the command at 0x08 and the status at 0x0C. Staging word k (k = 0..16) is at offset 0x10 + 4k. A register read returns its data in `reg_rdata_o` one clock after the read request. Unmapped offsets read 0.
- R3: Pointer bits [31:28] select the table. Codes 0x0, 0x4 and 0x8 select the packet table of parser 0, 1 and 2. Code 0xC selects the tree table, 0xD the search-tree table and 0xE the result table. Bits [27:0] are the entry index.
- R4: Command 1 (write) copies staging words 0..W-1 into the addressed entry. W is 4 for a packet table, 17 for the tree table, 17 for the search-tree table and 6 for the result table.
- R5: Command 2 (read) loads the addressed entry into staging words 0..W-1 and leaves staging words W..16 unchanged.
- R6: Accepting a command clears the status register. Consider the clock edge that captures the command write. At the second clock edge after it, the status register becomes equal to the command code. Bit 0 is write, bit 1 is read, bit 3 is add, bit 4 is delete and bit 5 is search.
- R7: Commands 8, 16 and 32 complete with their own status bit set and change no table entry.
- R8: A command is in progress from the capturing edge until the status update. During that time, writes to the command, pointer and staging registers are ignored.
- R9: A command write whose value is not 1, 2, 8, 16 or 32 is ignored: the status is unchanged and no table is accessed.
- R10: An index at or beyond the depth of the selected table still completes with its done bit set. The same holds for a table code not listed in R3. Such a command modifies no entry, and a read of this kind leaves the staging words unchanged. Depths are 16 for each packet table, 32 for the tree table, 8 for the search-tree table and 16 for the result table.
- R11: The packet tables of the three parsers are separate: a write to one parser's entry does not change the same index in another parser's table.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_re_i | input | 1 | Register read strobe |
| reg_addr_i | input | 8 | Register byte offset |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data, valid one clock after the read strobe |

## Verification
The hardest case to reach is the two-cycle window in which a command is in progress. Stimulus has to land a staging write, a pointer write or a second command exactly on the edges right after the command is captured. The bench issues these bus writes back to back, on the first and second edges after the command, with no idle cycle between them. It then reads back the pointer, the staging words and the status, which shows that each of those writes was dropped. A second subtle case is an oversized index whose low bits alias a valid entry. The bench writes through such an index and then reads the aliased entry to confirm that it is untouched.

// File: rtl/iac_pkg.sv
package iac_pkg;
  localparam int unsigned WORD_W = 32;

  typedef enum logic [2:0] {TGT_PKT, TGT_TREE, TGT_STREE, TGT_DB, TGT_NONE} tgt_e;
  typedef enum logic [1:0] {ST_IDLE, ST_EXEC, ST_FIN} st_e;

  localparam logic [3:0] CODE_TREE  = 4'hC;
  localparam logic [3:0] CODE_STREE = 4'hD;
  localparam logic [3:0] CODE_DB    = 4'hE;

  localparam logic [5:0] CMD_WR   = 6'd1;
  localparam logic [5:0] CMD_RD   = 6'd2;
  localparam logic [5:0] CMD_ADD  = 6'd8;
  localparam logic [5:0] CMD_DEL  = 6'd16;
  localparam logic [5:0] CMD_SRCH = 6'd32;

  function automatic logic cmd_known(input logic [31:0] c);
    return (c == 32'd1) || (c == 32'd2) || (c == 32'd8) ||
           (c == 32'd16) || (c == 32'd32);
  endfunction
endpackage

// File: rtl/iac_target_dec.sv
module iac_target_dec
  import iac_pkg::*;
#(
  parameter int unsigned N_PARSERS   = 3,
  parameter int unsigned PORT_W      = 2,
  parameter int unsigned PKT_DEPTH   = 16,
  parameter int unsigned TREE_DEPTH  = 32,
  parameter int unsigned STREE_DEPTH = 8,
  parameter int unsigned DB_DEPTH    = 16
) (
  input  logic [31:0]       ptr_i,
  output tgt_e              tgt_o,
  output logic [PORT_W-1:0] port_o,
  output logic [27:0]       idx_o,
  output logic              in_range_o
);
  logic [3:0]  code;
  logic [31:0] depth;

  assign code  = ptr_i[31:28];
  assign idx_o = ptr_i[27:0];

  always_comb begin
    tgt_o  = TGT_NONE;
    port_o = '0;
    depth  = '0;
    if (code == CODE_TREE) begin
      tgt_o = TGT_TREE;
      depth = TREE_DEPTH;
    end else if (code == CODE_STREE) begin
      tgt_o = TGT_STREE;
      depth = STREE_DEPTH;
    end else if (code == CODE_DB) begin
      tgt_o = TGT_DB;
      depth = DB_DEPTH;
    end else if (code[1:0] == 2'b00 && 32'(code[3:2]) < N_PARSERS) begin
      // packet tables sit at a stride of 4 codes per parser
      tgt_o  = TGT_PKT;
      port_o = PORT_W'(code[3:2]);
      depth  = PKT_DEPTH;
    end
  end

  assign in_range_o = (tgt_o != TGT_NONE) && ({4'b0, idx_o} < depth);
endmodule

// File: rtl/iac_mem.sv
module iac_mem
  import iac_pkg::*;
#(
  parameter int unsigned WORDS = 17,
  parameter int unsigned DEPTH = 16,
  localparam int unsigned AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int unsigned EW   = WORDS * WORD_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic          re_i,
  input  logic [27:0]   idx_i,
  input  logic [EW-1:0] wdata_i,
  output logic [EW-1:0] rdata_o
);
  logic [EW-1:0] mem_q [DEPTH];
  logic [AW-1:0] a;

  assign a = idx_i[AW-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
      rdata_o <= '0;
    end else begin
      if (we_i) mem_q[a] <= wdata_i;
      if (re_i) rdata_o <= mem_q[a];
    end
  end

  // R10
  no_oob_wr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |-> ({4'b0, idx_i} < 32'(DEPTH)));
  // R10
  no_oob_rd_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    re_i |-> ({4'b0, idx_i} < 32'(DEPTH)));
endmodule

// File: rtl/ind_access_ctrl.sv
module ind_access_ctrl
  import iac_pkg::*;
#(
  parameter int unsigned N_PARSERS   = 3,
  parameter int unsigned N_DATA      = 17,
  parameter int unsigned PKT_WORDS   = 4,
  parameter int unsigned TREE_WORDS  = 17,
  parameter int unsigned STREE_WORDS = 17,
  parameter int unsigned DB_WORDS    = 6,
  parameter int unsigned PKT_DEPTH   = 16,
  parameter int unsigned TREE_DEPTH  = 32,
  parameter int unsigned STREE_DEPTH = 8,
  parameter int unsigned DB_DEPTH    = 16,
  parameter int unsigned RA_W        = 8
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            reg_we_i,
  input  logic            reg_re_i,
  input  logic [RA_W-1:0] reg_addr_i,
  input  logic [31:0]     reg_wdata_i,
  output logic [31:0]     reg_rdata_o
);
  localparam int unsigned PORT_W   = (N_PARSERS > 1) ? $clog2(N_PARSERS) : 1;
  localparam int unsigned OFS_PTR  = 4;
  localparam int unsigned OFS_CMD  = 8;
  localparam int unsigned OFS_STAT = 12;
  localparam int unsigned OFS_DATA = 16;
  localparam int unsigned OFS_END  = OFS_DATA + 4 * N_DATA;
  localparam int unsigned STAGE_W  = N_DATA * WORD_W;

  logic [31:0]       ptr_q;
  logic [5:0]        cmd_q;
  logic [5:0]        status_q;
  logic [31:0]       stage_q [N_DATA];
  st_e               st_q;
  logic              busy;

  tgt_e              tgt;
  logic [PORT_W-1:0] port;
  logic [27:0]       idx;
  logic              in_rng;

  logic              hit_ptr, hit_cmd, hit_stat, hit_data;
  logic [RA_W-1:0]   didx;
  logic              cmd_acc;
  logic              exec_wr, exec_rd, fin_rd;
  logic [STAGE_W-1:0] stage_flat, rd_flat;
  int unsigned       nwords;
  logic [31:0]       rd_mux;

  assign busy = (st_q != ST_IDLE);

  // ---------------- register decode ----------------
  assign hit_ptr  = (reg_addr_i == RA_W'(OFS_PTR));
  assign hit_cmd  = (reg_addr_i == RA_W'(OFS_CMD));
  assign hit_stat = (reg_addr_i == RA_W'(OFS_STAT));
  assign hit_data = (reg_addr_i >= RA_W'(OFS_DATA)) && (reg_addr_i < RA_W'(OFS_END)) &&
                    (reg_addr_i[1:0] == 2'b00);
  assign didx     = (reg_addr_i - RA_W'(OFS_DATA)) >> 2;
  assign cmd_acc  = reg_we_i && hit_cmd && !busy && cmd_known(reg_wdata_i);

  iac_target_dec #(
    .N_PARSERS(N_PARSERS), .PORT_W(PORT_W), .PKT_DEPTH(PKT_DEPTH),
    .TREE_DEPTH(TREE_DEPTH), .STREE_DEPTH(STREE_DEPTH), .DB_DEPTH(DB_DEPTH)
  ) i_dec (
    .ptr_i(ptr_q), .tgt_o(tgt), .port_o(port), .idx_o(idx), .in_range_o(in_rng)
  );

  // ---------------- sequencer ----------------
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q     <= ST_IDLE;
      cmd_q    <= '0;
      status_q <= '0;
      ptr_q    <= '0;
    end else begin
      if (reg_we_i && hit_ptr && !busy) ptr_q <= reg_wdata_i;
      unique case (st_q)
        ST_IDLE: if (cmd_acc) begin
          cmd_q    <= reg_wdata_i[5:0];
          status_q <= '0;
          st_q     <= ST_EXEC;
        end
        ST_EXEC: st_q <= ST_FIN;
        ST_FIN: begin
          status_q <= cmd_q;
          st_q     <= ST_IDLE;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign exec_wr = (st_q == ST_EXEC) && (cmd_q == CMD_WR) && in_rng;
  assign exec_rd = (st_q == ST_EXEC) && (cmd_q == CMD_RD) && in_rng;
  assign fin_rd  = (st_q == ST_FIN)  && (cmd_q == CMD_RD) && in_rng;

  always_comb begin
    for (int k = 0; k < N_DATA; k++) stage_flat[k*WORD_W +: WORD_W] = stage_q[k];
  end

  // ---------------- tables ----------------
  logic [PKT_WORDS*WORD_W-1:0]   pkt_rd [N_PARSERS];
  logic [TREE_WORDS*WORD_W-1:0]  tree_rd;
  logic [STREE_WORDS*WORD_W-1:0] stree_rd;
  logic [DB_WORDS*WORD_W-1:0]    db_rd;

  for (genvar p = 0; p < N_PARSERS; p++) begin : g_pkt
    logic sel;
    assign sel = (tgt == TGT_PKT) && (port == PORT_W'(p));
    iac_mem #(.WORDS(PKT_WORDS), .DEPTH(PKT_DEPTH)) i_pkt_mem (
      .clk_i, .rst_ni,
      .we_i(exec_wr && sel), .re_i(exec_rd && sel), .idx_i(idx),
      .wdata_i(stage_flat[PKT_WORDS*WORD_W-1:0]), .rdata_o(pkt_rd[p])
    );
  end

  iac_mem #(.WORDS(TREE_WORDS), .DEPTH(TREE_DEPTH)) i_tree_mem (
    .clk_i, .rst_ni,
    .we_i(exec_wr && tgt == TGT_TREE), .re_i(exec_rd && tgt == TGT_TREE), .idx_i(idx),
    .wdata_i(stage_flat[TREE_WORDS*WORD_W-1:0]), .rdata_o(tree_rd)
  );

  iac_mem #(.WORDS(STREE_WORDS), .DEPTH(STREE_DEPTH)) i_stree_mem (
    .clk_i, .rst_ni,
    .we_i(exec_wr && tgt == TGT_STREE), .re_i(exec_rd && tgt == TGT_STREE), .idx_i(idx),
    .wdata_i(stage_flat[STREE_WORDS*WORD_W-1:0]), .rdata_o(stree_rd)
  );

  iac_mem #(.WORDS(DB_WORDS), .DEPTH(DB_DEPTH)) i_db_mem (
    .clk_i, .rst_ni,
    .we_i(exec_wr && tgt == TGT_DB), .re_i(exec_rd && tgt == TGT_DB), .idx_i(idx),
    .wdata_i(stage_flat[DB_WORDS*WORD_W-1:0]), .rdata_o(db_rd)
  );

  always_comb begin
    rd_flat = '0;
    nwords  = 0;
    unique case (tgt)
      TGT_PKT: begin
        nwords = PKT_WORDS;
        for (int p = 0; p < N_PARSERS; p++)
          if (port == PORT_W'(p)) rd_flat[PKT_WORDS*WORD_W-1:0] = pkt_rd[p];
      end
      TGT_TREE:  begin nwords = TREE_WORDS;  rd_flat[TREE_WORDS*WORD_W-1:0]  = tree_rd;  end
      TGT_STREE: begin nwords = STREE_WORDS; rd_flat[STREE_WORDS*WORD_W-1:0] = stree_rd; end
      TGT_DB:    begin nwords = DB_WORDS;    rd_flat[DB_WORDS*WORD_W-1:0]    = db_rd;    end
      default: ;
    endcase
  end

  // ---------------- staging bank ----------------
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int k = 0; k < N_DATA; k++) stage_q[k] <= '0;
    end else begin
      for (int k = 0; k < N_DATA; k++) begin
        if (fin_rd && k < nwords)
          stage_q[k] <= rd_flat[k*WORD_W +: WORD_W];
        else if (reg_we_i && hit_data && !busy && didx == RA_W'(k))
          stage_q[k] <= reg_wdata_i;
      end
    end
  end

  // ---------------- read port ----------------
  always_comb begin
    rd_mux = '0;
    if (hit_ptr)       rd_mux = ptr_q;
    else if (hit_cmd)  rd_mux = {26'b0, cmd_q};
    else if (hit_stat) rd_mux = {26'b0, status_q};
    else if (hit_data) begin
      for (int k = 0; k < N_DATA; k++)
        if (didx == RA_W'(k)) rd_mux = stage_q[k];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       reg_rdata_o <= '0;
    else if (reg_re_i) reg_rdata_o <= rd_mux;
  end

  // ---------------- checks ----------------
  // R6
  status_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(status_q));
  // R6
  status_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_acc |=> (status_q == '0));
  // R6
  done_code_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy) |-> (status_q == cmd_q));
  // R8
  busy_len_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy) |=> busy ##1 !busy);
  // R8
  ptr_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy && reg_we_i && hit_ptr) |=> $stable(ptr_q));
  // R8
  cmd_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy |=> $stable(cmd_q));
endmodule

// File: tb/test_ind_access_ctrl.sv
`timescale 1ns/1ps
module test_ind_access_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        we = 1'b0, re = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  int checks = 0, failures = 0;
  bit done = 0;

  always #2 clk = ~clk;

  ind_access_ctrl i_ind_access_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(we), .reg_re_i(re),
    .reg_addr_i(addr), .reg_wdata_i(wdata), .reg_rdata_o(rdata)
  );

  function automatic logic [31:0] pat(input logic [7:0] s, input int k);
    return {s, 8'(k), ~s, 8'(k) ^ 8'hA5};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  // all tasks start and end on a falling edge
  task automatic bus_wr(input logic [7:0] a, input logic [31:0] d);
    we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic bus_rd(input logic [7:0] a, output logic [31:0] d);
    re = 1'b1; addr = a;
    @(negedge clk);
    re = 1'b0;
    d = rdata;
  endtask

  task automatic do_cmd(input logic [31:0] c);
    bus_wr(8'h08, c);
    repeat (2) @(negedge clk);
  endtask

  task automatic load_stage(input logic [7:0] s);
    for (int k = 0; k < 17; k++) bus_wr(8'(16 + 4 * k), pat(s, k));
  endtask

  task automatic zero_stage();
    for (int k = 0; k < 17; k++) bus_wr(8'(16 + 4 * k), 32'h0);
  endtask

  task automatic rd_stage(input string req, input int k, input logic [31:0] exp);
    logic [31:0] d;
    bus_rd(8'(16 + 4 * k), d);
    chk(req, d, exp);
  endtask

  task automatic rd_stat(input string req, input logic [31:0] exp);
    logic [31:0] d;
    bus_rd(8'h0C, d);
    chk(req, d, exp);
  endtask

  task automatic t_reset();
    logic [31:0] d;
    bus_rd(8'h04, d); chk("R1 ptr", d, 0);
    bus_rd(8'h08, d); chk("R1 cmd", d, 0);
    rd_stat("R1 status", 0);
    rd_stage("R1 stage0", 0, 0);
    rd_stage("R1 stage16", 16, 0);
    load_stage(8'h11);
    bus_wr(8'h04, 32'hC000_0003);
    do_cmd(2);
    rd_stage("R1 tree entry zero w0", 0, 0);
    rd_stage("R1 tree entry zero w16", 16, 0);
  endtask

  task automatic t_regmap();
    logic [31:0] d;
    bus_wr(8'h04, 32'hC000_0005);
    bus_rd(8'h04, d); chk("R2 ptr readback", d, 32'hC000_0005);
    load_stage(8'h22);
    for (int k = 0; k < 17; k++) rd_stage("R2 stage readback", k, pat(8'h22, k));
    bus_rd(8'h00, d); chk("R2 unmapped 0x00", d, 0);
    bus_rd(8'h54, d); chk("R2 unmapped 0x54", d, 0);
  endtask

  task automatic t_tree();
    logic [31:0] d;
    bus_wr(8'h04, 32'hC000_0003);
    load_stage(8'h33);
    do_cmd(1);
    rd_stat("R6 write done", 1);
    bus_rd(8'h08, d); chk("R2 cmd readback", d, 1);
    zero_stage();
    do_cmd(2);
    rd_stat("R6 read done", 2);
    for (int k = 0; k < 17; k++) rd_stage("R4 tree roundtrip", k, pat(8'h33, k));
  endtask

  task automatic t_db();
    bus_wr(8'h04, 32'hE000_0002);
    load_stage(8'h44);
    do_cmd(1);
    load_stage(8'h55);
    do_cmd(2);
    for (int k = 0; k < 6; k++)  rd_stage("R5 db loaded word", k, pat(8'h44, k));
    for (int k = 6; k < 17; k++) rd_stage("R5 db upper kept", k, pat(8'h55, k));
  endtask

  task automatic t_pkt();
    for (int p = 0; p < 3; p++) begin
      bus_wr(8'h04, {4'(4 * p), 28'd5});
      load_stage(8'(8'h60 + p));
      do_cmd(1);
    end
    for (int p = 0; p < 3; p++) begin
      bus_wr(8'h04, {4'(4 * p), 28'd5});
      zero_stage();
      do_cmd(2);
      for (int k = 0; k < 4; k++) rd_stage("R11 parser table", k, pat(8'(8'h60 + p), k));
      rd_stage("R4 pkt width 4", 4, 0);
    end
    bus_wr(8'h04, 32'hD000_0001);
    load_stage(8'h77);
    do_cmd(1);
    bus_wr(8'h04, 32'hC000_0001);
    do_cmd(2);
    rd_stage("R3 tree separate from stree", 0, 0);
    bus_wr(8'h04, 32'hD000_0001);
    do_cmd(2);
    rd_stage("R3 stree entry", 0, pat(8'h77, 0));
    rd_stage("R3 stree entry w16", 16, pat(8'h77, 16));
  endtask

  task automatic t_stree_ops();
    load_stage(8'h88);
    bus_wr(8'h04, 32'hD000_0001);
    do_cmd(8);  rd_stat("R7 add done", 8);
    do_cmd(16); rd_stat("R7 del done", 16);
    do_cmd(32); rd_stat("R7 search done", 32);
    zero_stage();
    do_cmd(2);
    rd_stage("R7 entry untouched", 0, pat(8'h77, 0));
  endtask

  task automatic t_busy();
    logic [31:0] d;
    bus_wr(8'h04, 32'hC000_0007);
    load_stage(8'h99);
    bus_wr(8'h08, 1);             // captured E0
    bus_wr(8'h10, 32'hDEAD_BEEF); // E1, busy
    bus_wr(8'h08, 2);             // E2, busy
    @(negedge clk);
    rd_stat("R8 second cmd dropped", 1);
    rd_stage("R8 stage write dropped", 0, pat(8'h99, 0));
    zero_stage();
    bus_wr(8'h08, 2);
    bus_wr(8'h04, 32'hC000_0009); // busy
    @(negedge clk);
    bus_rd(8'h04, d); chk("R8 ptr write dropped", d, 32'hC000_0007);
    rd_stat("R8 read done", 2);
    rd_stage("R8 entry written", 0, pat(8'h99, 0));
  endtask

  task automatic t_badcmd();
    do_cmd(3); rd_stat("R9 cmd 3 ignored", 2);
    do_cmd(0); rd_stat("R9 cmd 0 ignored", 2);
    do_cmd(4); rd_stat("R9 cmd 4 ignored", 2);
    load_stage(8'hAB);
    do_cmd(5);
    rd_stat("R9 cmd 5 ignored", 2);
    zero_stage();
    do_cmd(2);
    rd_stage("R9 entry untouched", 0, pat(8'h99, 0));
  endtask

  task automatic t_range();
    load_stage(8'hBC);
    bus_wr(8'h04, 32'hC000_0020);
    do_cmd(1); rd_stat("R10 oob write done", 1);
    bus_wr(8'h04, 32'hC100_0007);
    do_cmd(1);
    bus_wr(8'h04, 32'hF000_0000);
    do_cmd(1); rd_stat("R10 bad code done", 1);
    bus_wr(8'h04, 32'h1000_0000);
    do_cmd(1);
    zero_stage();
    bus_wr(8'h04, 32'hC000_0000);
    do_cmd(2);
    rd_stage("R10 alias entry 0 untouched", 0, 0);
    bus_wr(8'h04, 32'hC000_0007);
    do_cmd(2);
    rd_stage("R10 alias entry 7 untouched", 0, pat(8'h99, 0));
    load_stage(8'hCD);
    bus_wr(8'h04, 32'hC000_0028);
    do_cmd(2);
    rd_stat("R10 oob read done", 2);
    rd_stage("R10 oob read keeps stage", 0, pat(8'hCD, 0));
    bus_wr(8'h04, 32'h0000_0010);
    do_cmd(2);
    rd_stage("R10 pkt oob read keeps stage", 3, pat(8'hCD, 3));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_regmap();
    t_tree();
    t_db();
    t_pkt();
    t_stree_ops();
    t_busy();
    t_badcmd();
    t_range();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=%08h expected=%08h", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule